// File: doc/BRIEF.md
# Serial NAND Bring-Up Sequencer

After reset, this block brings a serial NAND device into a known state without any help from software. It does not drive the SPI pins. Instead, it sends a short series of commands to a separate single-lane SPI command engine. Each command is a request that the engine acknowledges with a one-cycle pulse, and that pulse carries any bytes the engine read back.

The sequence runs as follows:

1. The block reads the device identity.
2. It checks that a device is present.
3. It looks the identity up in a table of up to eight supported devices. The table is a parameter.
4. It lifts the array write protection.
5. If the matched table entry allows it, the block turns on four-lane operation. It does this with a read-modify-write of one feature register, and writes only when the enable bit is still clear.

At the end, the block reports a result code and the lane counts and cache opcodes that the data path should use from then on. It holds all of these results until the next reset.

Top module: `nand_setup_seq`

## Requirements
- R1: The first request is opcode 0x9F with an address phase of byte 0x00 and a three-byte read. The response returns the first ID byte in `cmd_rdata[23:16]` and the second in `cmd_rdata[15:8]`. These two bytes form the 16-bit lookup key, with the first byte as the high half.
- R2: If the first ID byte is 0xFF or 0x00, the block issues no further request and reports status 2 (no device).
- R3: If the key matches none of the first `N_ENTRIES` table slots, the block issues no further request and reports status 3 (unsupported). Slots at or beyond `N_ENTRIES` never match.
- R4: A supported device next receives two requests. The first is opcode 0x06 with no address and no data. The second is opcode 0x1F with address 0xA0 and write byte 0x00.
- R5: If the entry does not support four-lane read, or its enable-bit index is 0xFF, no further request follows the protection clear.
- R6: Otherwise, the block issues opcode 0x0F at the entry's feature address with a one-byte read, returned in `cmd_rdata[7:0]`. If the bit named by the index is already set, nothing more is sent. If the bit is clear, the block sends 0x06 and then 0x1F at the same address, with the byte read OR the bit.
- R7: By default, reads use 1 lane with opcode 0x03 and programs use 1 lane with opcode 0x02. Reads use 4 lanes with opcode 0x6B when the entry supports four-lane read and the enable step has completed or was skipped for index 0xFF. Programs use 4 lanes with opcode 0x32 only when the entry supports four-lane program and four-lane read is active.
- R8: `cmd_req` stays high with stable command fields until `cmd_ack` is sampled high. It is then low for at least one cycle before the next request.
- R9: `setup_done` rises at the second rising edge counted from the edge that samples the final `cmd_ack` (that edge is the first). From then until reset, `setup_done`, the status and the mode outputs hold their values. Status 1 means the setup completed.
- R10: During and just after reset, `setup_done` is 0, status is 0 (busy), `cmd_req` is 0, and the mode outputs show the single-lane defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | output | 1 | Command request, held until acknowledged |
| cmd_op | output | 8 | Command opcode |
| cmd_addr_en | output | 1 | Send one address byte |
| cmd_addr | output | 8 | Address byte |
| cmd_wr_en | output | 1 | Send one data byte |
| cmd_wdata | output | 8 | Data byte to send |
| cmd_rd_len | output | 2 | Number of bytes to read back (0 to 3) |
| cmd_ack | input | 1 | One-cycle completion pulse from the engine |
| cmd_rdata | input | 24 | Read bytes, right-aligned, last byte in [7:0] |
| setup_done | output | 1 | Sequence finished |
| setup_status | output | 2 | 0 busy, 1 ok, 2 no device, 3 unsupported |
| rd_lanes | output | 3 | Lanes for page reads (1 or 4) |
| rd_opcode | output | 8 | Cache read opcode |
| pg_lanes | output | 3 | Lanes for page programs (1 or 4) |
| pg_opcode | output | 8 | Cache program opcode |

## Verification
A request is due one cycle after the previous acknowledge at the earliest. The bench engine answers after a latency chosen per scenario, from zero to three cycles. The bench compares each new request with the head of a queue it built from the device ID, table and feature contents. It sampled the acknowledge on a falling edge; on the next falling edge it checks that `cmd_req` has dropped. The bench expects `setup_done` and the final modes exactly two falling edges after that acknowledge, and it expects the busy defaults on every earlier cycle. Both are compared on every clock, so a result that arrives early or late is flagged in the cycle where it occurs.

// File: rtl/nand_setup_pkg.sv
package nand_setup_pkg;

    localparam int unsigned MAX_ENTRIES = 8;

    localparam logic [7:0] OP_READ_ID  = 8'h9F;
    localparam logic [7:0] OP_WR_ENA   = 8'h06;
    localparam logic [7:0] OP_GET_FEAT = 8'h0F;
    localparam logic [7:0] OP_SET_FEAT = 8'h1F;
    localparam logic [7:0] OP_RD_X1    = 8'h03;
    localparam logic [7:0] OP_RD_X4    = 8'h6B;
    localparam logic [7:0] OP_PG_X1    = 8'h02;
    localparam logic [7:0] OP_PG_X4    = 8'h32;
    localparam logic [7:0] FEAT_LOCK   = 8'hA0;
    localparam logic [7:0] QBIT_NONE   = 8'hFF;

    typedef struct packed {
        logic [15:0] id;
        logic        quad_rd;
        logic        quad_pg;
        logic [7:0]  qe_addr;
        logic [7:0]  qe_bit;
    } nand_entry_t;

    typedef enum logic [1:0] {
        STAT_BUSY  = 2'd0,
        STAT_OK    = 2'd1,
        STAT_NODEV = 2'd2,
        STAT_UNSUP = 2'd3
    } setup_status_e;

    typedef enum logic [3:0] {
        S_RDID, S_IDCHK, S_WREN_P, S_CLRP, S_QDEC,
        S_RDQE, S_QEVAL, S_WREN_Q, S_WRQE, S_WRAP, S_DONE
    } seq_state_e;

    typedef struct packed {
        logic [7:0] op;
        logic       addr_en;
        logic [7:0] addr;
        logic       wr_en;
        logic [7:0] wdata;
        logic [1:0] rd_len;
    } cmd_t;

    typedef struct packed {
        logic [2:0] rd_lanes;
        logic [7:0] rd_op;
        logic [2:0] pg_lanes;
        logic [7:0] pg_op;
    } mode_t;

    function automatic nand_entry_t make_entry(input logic [15:0] id, input logic qrd,
                                               input logic qpg, input logic [7:0] addr,
                                               input logic [7:0] bitx);
        nand_entry_t e;
        e.id      = id;
        e.quad_rd = qrd;
        e.quad_pg = qpg;
        e.qe_addr = addr;
        e.qe_bit  = bitx;
        return e;
    endfunction

    function automatic mode_t pick_mode(input logic quad_rd_on, input logic pg_cap);
        mode_t m;
        m.rd_lanes = quad_rd_on ? 3'd4 : 3'd1;
        m.rd_op    = quad_rd_on ? OP_RD_X4 : OP_RD_X1;
        m.pg_lanes = (quad_rd_on && pg_cap) ? 3'd4 : 3'd1;
        m.pg_op    = (quad_rd_on && pg_cap) ? OP_PG_X4 : OP_PG_X1;
        return m;
    endfunction

    localparam nand_entry_t [MAX_ENTRIES-1:0] DEFAULT_TABLE = {
        nand_entry_t'(0), nand_entry_t'(0), nand_entry_t'(0), nand_entry_t'(0),
        make_entry(16'h98C2, 1'b0, 1'b0, 8'hB0, QBIT_NONE),
        make_entry(16'h2C12, 1'b1, 1'b1, 8'hB0, 8'd0),
        make_entry(16'hEFAA, 1'b1, 1'b1, 8'hB0, QBIT_NONE),
        make_entry(16'hC8F1, 1'b1, 1'b1, 8'hB0, 8'd0)
    };

endpackage

// File: rtl/nand_id_lookup.sv
module nand_id_lookup
    import nand_setup_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 4,
    parameter nand_entry_t [MAX_ENTRIES-1:0] ENTRY_TABLE = DEFAULT_TABLE
) (
    input  logic [15:0] key,
    output logic        hit,
    output nand_entry_t entry
);
    logic [MAX_ENTRIES-1:0] match;

    for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_slot
        if (g < N_ENTRIES) begin : g_live
            assign match[g] = (ENTRY_TABLE[g].id == key);
        end else begin : g_off
            assign match[g] = 1'b0;
        end
    end

    always_comb begin
        hit   = |match;
        entry = '0;
        for (int i = MAX_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) entry = ENTRY_TABLE[i];
        end
    end
endmodule

// File: rtl/nand_cmd_builder.sv
module nand_cmd_builder
    import nand_setup_pkg::*;
(
    input  seq_state_e  state,
    input  nand_entry_t entry,
    input  logic [7:0]  qe_val,
    output logic        is_cmd,
    output cmd_t        cmd
);
    logic [7:0] qe_mask;
    assign qe_mask = 8'h01 << entry.qe_bit[2:0];

    always_comb begin
        cmd    = '0;
        is_cmd = 1'b1;
        unique case (state)
            S_RDID: begin
                cmd.op      = OP_READ_ID;
                cmd.addr_en = 1'b1;
                cmd.addr    = 8'h00;
                cmd.rd_len  = 2'd3;
            end
            S_WREN_P, S_WREN_Q: cmd.op = OP_WR_ENA;
            S_CLRP: begin
                cmd.op      = OP_SET_FEAT;
                cmd.addr_en = 1'b1;
                cmd.addr    = FEAT_LOCK;
                cmd.wr_en   = 1'b1;
                cmd.wdata   = 8'h00;
            end
            S_RDQE: begin
                cmd.op      = OP_GET_FEAT;
                cmd.addr_en = 1'b1;
                cmd.addr    = entry.qe_addr;
                cmd.rd_len  = 2'd1;
            end
            S_WRQE: begin
                cmd.op      = OP_SET_FEAT;
                cmd.addr_en = 1'b1;
                cmd.addr    = entry.qe_addr;
                cmd.wr_en   = 1'b1;
                cmd.wdata   = qe_val | qe_mask;
            end
            default: is_cmd = 1'b0;
        endcase
    end
endmodule

// File: rtl/nand_setup_seq.sv
module nand_setup_seq
    import nand_setup_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 4,
    parameter nand_entry_t [MAX_ENTRIES-1:0] ENTRY_TABLE = DEFAULT_TABLE
) (
    input  logic        clk,
    input  logic        rst,
    output logic        cmd_req,
    output logic [7:0]  cmd_op,
    output logic        cmd_addr_en,
    output logic [7:0]  cmd_addr,
    output logic        cmd_wr_en,
    output logic [7:0]  cmd_wdata,
    output logic [1:0]  cmd_rd_len,
    input  logic        cmd_ack,
    input  logic [23:0] cmd_rdata,
    output logic        setup_done,
    output logic [1:0]  setup_status,
    output logic [2:0]  rd_lanes,
    output logic [7:0]  rd_opcode,
    output logic [2:0]  pg_lanes,
    output logic [7:0]  pg_opcode
);
    seq_state_e    state;
    logic          gap;
    logic [15:0]   id_q;
    logic [7:0]    qe_val_q;
    logic          done_q;
    setup_status_e status_q;
    mode_t         mode_q;

    logic          hit;
    nand_entry_t   entry;
    logic          is_cmd;
    cmd_t          cmd;
    logic          fire;

    nand_id_lookup #(
        .N_ENTRIES  (N_ENTRIES),
        .ENTRY_TABLE(ENTRY_TABLE)
    ) u_lookup (
        .key  (id_q),
        .hit  (hit),
        .entry(entry)
    );

    nand_cmd_builder u_build (
        .state (state),
        .entry (entry),
        .qe_val(qe_val_q),
        .is_cmd(is_cmd),
        .cmd   (cmd)
    );

    assign cmd_req = is_cmd && !gap;
    assign fire    = cmd_req && cmd_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_RDID;
            gap      <= 1'b1;
            id_q     <= '0;
            qe_val_q <= '0;
            done_q   <= 1'b0;
            status_q <= STAT_BUSY;
            mode_q   <= pick_mode(1'b0, 1'b0);
        end else begin
            gap <= fire;
            unique case (state)
                S_RDID: if (fire) begin
                    id_q  <= cmd_rdata[23:8];
                    state <= S_IDCHK;
                end
                S_IDCHK: begin
                    if (id_q[15:8] == 8'hFF || id_q[15:8] == 8'h00) begin
                        state    <= S_DONE;
                        done_q   <= 1'b1;
                        status_q <= STAT_NODEV;
                    end else if (!hit) begin
                        state    <= S_DONE;
                        done_q   <= 1'b1;
                        status_q <= STAT_UNSUP;
                    end else begin
                        state <= S_WREN_P;
                    end
                end
                S_WREN_P: if (fire) state <= S_CLRP;
                S_CLRP:   if (fire) state <= S_QDEC;
                S_QDEC: begin
                    if (!entry.quad_rd || entry.qe_bit == QBIT_NONE) begin
                        state    <= S_DONE;
                        done_q   <= 1'b1;
                        status_q <= STAT_OK;
                        mode_q   <= pick_mode(entry.quad_rd, entry.quad_pg);
                    end else begin
                        state <= S_RDQE;
                    end
                end
                S_RDQE: if (fire) begin
                    qe_val_q <= cmd_rdata[7:0];
                    state    <= S_QEVAL;
                end
                S_QEVAL: begin
                    if (qe_val_q[entry.qe_bit[2:0]]) begin
                        state    <= S_DONE;
                        done_q   <= 1'b1;
                        status_q <= STAT_OK;
                        mode_q   <= pick_mode(1'b1, entry.quad_pg);
                    end else begin
                        state <= S_WREN_Q;
                    end
                end
                S_WREN_Q: if (fire) state <= S_WRQE;
                S_WRQE:   if (fire) state <= S_WRAP;
                S_WRAP: begin
                    state    <= S_DONE;
                    done_q   <= 1'b1;
                    status_q <= STAT_OK;
                    mode_q   <= pick_mode(1'b1, entry.quad_pg);
                end
                default: state <= S_DONE;
            endcase
        end
    end

    assign cmd_op       = cmd.op;
    assign cmd_addr_en  = cmd.addr_en;
    assign cmd_addr     = cmd.addr;
    assign cmd_wr_en    = cmd.wr_en;
    assign cmd_wdata    = cmd.wdata;
    assign cmd_rd_len   = cmd.rd_len;
    assign setup_done   = done_q;
    assign setup_status = status_q;
    assign rd_lanes     = mode_q.rd_lanes;
    assign rd_opcode    = mode_q.rd_op;
    assign pg_lanes     = mode_q.pg_lanes;
    assign pg_opcode    = mode_q.pg_op;
endmodule

// File: rtl/nand_setup_seq_chk.sv
module nand_setup_seq_chk
    import nand_setup_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cmd_req,
    input logic [7:0]  cmd_op,
    input logic        cmd_addr_en,
    input logic [7:0]  cmd_addr,
    input logic        cmd_wr_en,
    input logic [7:0]  cmd_wdata,
    input logic [1:0]  cmd_rd_len,
    input logic        cmd_ack,
    input logic        setup_done,
    input logic [1:0]  setup_status,
    input logic [2:0]  rd_lanes,
    input logic [7:0]  rd_opcode,
    input logic [2:0]  pg_lanes,
    input logic [7:0]  pg_opcode
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op) && $stable(cmd_addr_en)
            && $stable(cmd_addr) && $stable(cmd_wr_en) && $stable(cmd_wdata)
            && $stable(cmd_rd_len)));

    // R8
    req_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_ack) |=> !cmd_req);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        setup_done |=> (setup_done && $stable(setup_status) && $stable(rd_lanes)
            && $stable(rd_opcode) && $stable(pg_lanes) && $stable(pg_opcode)));

    // R9
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        setup_done |-> !cmd_req);

    // R9
    status_done_chk: assert property (@(posedge clk) disable iff (rst)
        setup_done == (setup_status != 2'd0));

    // R7
    quad_pg_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (setup_done && pg_lanes == 3'd4) |-> (rd_lanes == 3'd4 && rd_opcode == OP_RD_X4));
endmodule

bind nand_setup_seq nand_setup_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_req     (cmd_req),
    .cmd_op      (cmd_op),
    .cmd_addr_en (cmd_addr_en),
    .cmd_addr    (cmd_addr),
    .cmd_wr_en   (cmd_wr_en),
    .cmd_wdata   (cmd_wdata),
    .cmd_rd_len  (cmd_rd_len),
    .cmd_ack     (cmd_ack),
    .setup_done  (setup_done),
    .setup_status(setup_status),
    .rd_lanes    (rd_lanes),
    .rd_opcode   (rd_opcode),
    .pg_lanes    (pg_lanes),
    .pg_opcode   (pg_opcode)
);

// File: tb/nand_setup_seq_test.sv
module nand_setup_seq_test;
    import nand_setup_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned NENT = 5;
    localparam nand_entry_t [MAX_ENTRIES-1:0] TB_TABLE = {
        nand_entry_t'(0), nand_entry_t'(0),
        make_entry(16'h1111, 1'b1, 1'b1, 8'hB0, 8'hFF),
        make_entry(16'hC952, 1'b1, 1'b1, 8'hB0, 8'd6),
        make_entry(16'h98C2, 1'b0, 1'b1, 8'hB0, 8'hFF),
        make_entry(16'h2C12, 1'b1, 1'b0, 8'hB0, 8'd0),
        make_entry(16'hEFAA, 1'b1, 1'b1, 8'hB0, 8'hFF),
        make_entry(16'hC8F1, 1'b1, 1'b1, 8'hB0, 8'd0)
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_req, cmd_addr_en, cmd_wr_en, setup_done;
    logic [7:0] cmd_op, cmd_addr, cmd_wdata, rd_opcode, pg_opcode;
    logic [1:0] cmd_rd_len, setup_status;
    logic [2:0] rd_lanes, pg_lanes;
    logic cmd_ack = 1'b0;
    logic [23:0] cmd_rdata = '0;

    always #2.5 clk = ~clk;

    nand_setup_seq #(.N_ENTRIES(NENT), .ENTRY_TABLE(TB_TABLE)) uut (
        .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_addr_en(cmd_addr_en), .cmd_addr(cmd_addr), .cmd_wr_en(cmd_wr_en),
        .cmd_wdata(cmd_wdata), .cmd_rd_len(cmd_rd_len), .cmd_ack(cmd_ack),
        .cmd_rdata(cmd_rdata), .setup_done(setup_done), .setup_status(setup_status),
        .rd_lanes(rd_lanes), .rd_opcode(rd_opcode), .pg_lanes(pg_lanes),
        .pg_opcode(pg_opcode)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] feat [256];
    logic [27:0] exp_q [$];
    logic [1:0]  exp_stat;
    logic [21:0] exp_mode;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [27:0] pack_cmd(input logic [7:0] op, input logic ae,
            input logic [7:0] a, input logic we, input logic [7:0] wd, input logic [1:0] rl);
        return {op, ae, a, we, wd, rl};
    endfunction

    task automatic run(input logic [7:0] id0, input logic [7:0] id1,
                       input logic [7:0] init_b0, input int lat);
        int idx;
        bit quad;
        bit qpg;
        logic [7:0] v;
        int cyc;
        int last_ack;
        int wait_n;
        bit serving;
        bit exp_done;
        logic [27:0] head;
        bit seen_done;

        for (int i = 0; i < 256; i++) feat[i] = 8'h00;
        feat[8'hA0] = 8'h38;
        feat[8'hB0] = init_b0;

        // expected sequence from R1..R7
        exp_q.delete();
        exp_q.push_back(pack_cmd(8'h9F, 1'b1, 8'h00, 1'b0, 8'h00, 2'd3));
        quad = 1'b0;
        qpg = 1'b0;
        if (id0 == 8'hFF || id0 == 8'h00) begin
            exp_stat = 2'd2;
        end else begin
            idx = -1;
            for (int i = 0; i < NENT; i++)
                if (idx < 0 && TB_TABLE[i].id == {id0, id1}) idx = i;
            if (idx < 0) begin
                exp_stat = 2'd3;
            end else begin
                exp_stat = 2'd1;
                exp_q.push_back(pack_cmd(8'h06, 1'b0, 8'h00, 1'b0, 8'h00, 2'd0));
                exp_q.push_back(pack_cmd(8'h1F, 1'b1, 8'hA0, 1'b1, 8'h00, 2'd0));
                qpg = TB_TABLE[idx].quad_pg;
                if (TB_TABLE[idx].quad_rd) begin
                    if (TB_TABLE[idx].qe_bit == 8'hFF) begin
                        quad = 1'b1;
                    end else begin
                        exp_q.push_back(pack_cmd(8'h0F, 1'b1, TB_TABLE[idx].qe_addr, 1'b0, 8'h00, 2'd1));
                        v = (TB_TABLE[idx].qe_addr == 8'hA0) ? 8'h00 : feat[TB_TABLE[idx].qe_addr];
                        if (!v[TB_TABLE[idx].qe_bit[2:0]]) begin
                            exp_q.push_back(pack_cmd(8'h06, 1'b0, 8'h00, 1'b0, 8'h00, 2'd0));
                            exp_q.push_back(pack_cmd(8'h1F, 1'b1, TB_TABLE[idx].qe_addr, 1'b1,
                                v | (8'h01 << TB_TABLE[idx].qe_bit[2:0]), 2'd0));
                        end
                        quad = 1'b1;
                    end
                end
            end
        end
        exp_mode = {quad ? 3'd4 : 3'd1, quad ? 8'h6B : 8'h03,
                    (quad && qpg) ? 3'd4 : 3'd1, (quad && qpg) ? 8'h32 : 8'h02};

        // R10 reset state
        rst = 1'b1;
        cmd_ack = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 done", {31'd0, setup_done}, 32'd0);
        check("R10 status", {30'd0, setup_status}, 32'd0);
        check("R10 req", {31'd0, cmd_req}, 32'd0);
        check("R10 modes", {10'd0, rd_lanes, rd_opcode, pg_lanes, pg_opcode},
              {10'd0, 3'd1, 8'h03, 3'd1, 8'h02});
        rst = 1'b0;

        cyc = 0;
        last_ack = -100;
        serving = 1'b0;
        wait_n = 0;
        seen_done = 1'b0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            cyc++;
            exp_done = (exp_q.size() == 0) && !serving && !cmd_ack && (cyc >= last_ack + 2);
            // R9 done timing and hold; R2 R3 R7 results
            check("R9 done", {31'd0, setup_done}, {31'd0, exp_done});
            if (exp_done) begin
                seen_done = 1'b1;
                check("R2 R3 status", {30'd0, setup_status}, {30'd0, exp_stat});
                check("R7 modes", {10'd0, rd_lanes, rd_opcode, pg_lanes, pg_opcode},
                      {10'd0, exp_mode});
                check("R9 no req after done", {31'd0, cmd_req}, 32'd0);
            end else begin
                check("R9 busy status", {30'd0, setup_status}, 32'd0);
                check("R7 default modes", {10'd0, rd_lanes, rd_opcode, pg_lanes, pg_opcode},
                      {10'd0, 3'd1, 8'h03, 3'd1, 8'h02});
            end

            if (cmd_ack) begin
                cmd_ack = 1'b0;
                check("R8 gap", {31'd0, cmd_req}, 32'd0);
            end else begin
                if (!serving && cmd_req) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R2 R3 R5 R6 unexpected request actual=%h expected=none",
                                 {cmd_op, cmd_addr_en, cmd_addr, cmd_wr_en, cmd_wdata, cmd_rd_len});
                        head = {cmd_op, cmd_addr_en, cmd_addr, cmd_wr_en, cmd_wdata, cmd_rd_len};
                    end else begin
                        head = exp_q.pop_front();
                        // R1 R4 R5 R6 command contents
                        if ({cmd_op, cmd_addr_en, cmd_addr, cmd_wr_en, cmd_wdata, cmd_rd_len} !== head) begin
                            errors++;
                            $display("FAIL R1 R4 R6 request actual=%h expected=%h",
                                     {cmd_op, cmd_addr_en, cmd_addr, cmd_wr_en, cmd_wdata, cmd_rd_len}, head);
                        end
                    end
                    serving = 1'b1;
                    wait_n = lat;
                end else if (serving) begin
                    if (wait_n > 0) wait_n--;
                end
                if (serving && wait_n == 0) begin
                    check("R8 held", {31'd0, cmd_req}, 32'd1);
                    if (head[27:20] == 8'h9F) cmd_rdata = {id0, id1, 8'h5A};
                    else if (head[27:20] == 8'h0F) cmd_rdata = {16'h0, feat[head[18:11]]};
                    else cmd_rdata = 24'h0;
                    if (head[27:20] == 8'h1F) feat[head[18:11]] = head[9:2];
                    cmd_ack = 1'b1;
                    serving = 1'b0;
                    last_ack = cyc;
                end
            end
            if (seen_done && cyc > last_ack + 8) break;
        end
        check("R9 finished", {31'd0, seen_done}, 32'd1);
    endtask

    initial begin
        run(8'hFF, 8'hF1, 8'h00, 1);   // R2 first byte FF
        run(8'h00, 8'hAA, 8'h00, 0);   // R2 first byte 00
        run(8'h12, 8'h34, 8'h00, 2);   // R3 no match
        run(8'h11, 8'h11, 8'h00, 1);   // R3 slot beyond N_ENTRIES
        run(8'hC8, 8'hF1, 8'h10, 0);   // R6 bit clear, write back 0x11
        run(8'hC8, 8'hF1, 8'h01, 3);   // R6 bit already set
        run(8'hEF, 8'hAA, 8'h00, 2);   // R5 index FF, quad on
        run(8'h2C, 8'h12, 8'h00, 1);   // R7 quad read, single program
        run(8'h98, 8'hC2, 8'h00, 0);   // R5 R7 no quad read blocks quad program
        run(8'hC9, 8'h52, 8'h80, 3);   // R6 bit 6 OR into 0x80
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule